// File: doc/BRIEF.md
# Ten-bit serializer with internal loopback

This block turns a stream of 10-bit line code groups into a serial bit stream, one bit per fast bit-clock, least significant bit first. The bit-clock runs ten times faster than the word rate. A one-cycle load strobe, arriving once every ten bit-clocks, stands in for the slow reference edge. The word present at that strobe is captured, moved into a shift register and shifted out. It then passes through a retiming delay line, so bit 0 reaches the line a fixed eleven bit-clocks after the capturing edge.

When the loopback input is high, the line output is parked high and its complement low. The same serial stream, with the same timing, appears on an internal receive-side output instead. A strobe that comes too early while a word is still being shifted is ignored, so a word in flight is never cut short.

Top module: `ser10_tx`

## Requirements
- R1: While reset is high and after it is released, `line_p` is 0, `line_n` is 1 and `loop_bit` is 0 until the first captured word reaches the line.
- R2: The word on `word_in` is sampled on the clock edge at which an accepted `load_stb` is high. Later changes to `word_in` do not alter the transmitted bits.
- R3: A word is sent one bit per clock, bit 0 first and bit 9 last.
- R4: Bit 0 of a word is on the serial output after the 11th rising edge that follows the capturing edge. Bit k follows k edges later.
- R5: Strobes spaced exactly ten clocks apart give a continuous stream: bit 9 of one word is directly followed by bit 0 of the next.
- R6: A strobe is accepted only if at least ten clocks have passed since the previous accepted strobe, or if none has been accepted yet. Earlier strobes are ignored, and so are their words.
- R7: When no new word follows, the serial output returns to 0 after bit 9.
- R8: One edge after `loop_en` is sampled high, `line_p` is 1 and `line_n` is 0. `loop_bit` then carries the serial stream with the same timing as in R4.
- R9: One edge after `loop_en` is sampled low, `line_p` carries the serial stream and `loop_bit` is 0. `line_n` is always the complement of `line_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-clock |
| rst | input | 1 | Synchronous reset, active high |
| load_stb | input | 1 | Word load strobe, nominally one in ten clocks |
| word_in | input | 10 | Code group to send, bit 0 sent first |
| loop_en | input | 1 | Loopback enable |
| line_p | output | 1 | Serial line output, true polarity |
| line_n | output | 1 | Serial line output, complement |
| loop_bit | output | 1 | Serial stream toward the internal receive path |

## Verification
A wrong remaining-bit count or a stuck pending flag shows at the ports as a missing, doubled or shifted bit. It appears within eleven to twenty clocks of the affected strobe, because every bit passes the same fixed delay line. A bad acceptance window shows as a word that cuts into its predecessor, or as a lost word, in the next word slot. A fault in the line stage shows one clock after `loop_en` changes, as a line that is not parked or a receive output that is not quiet. The bench sweeps every 10-bit value back to back, both in normal mode and in loopback. It predicts each output bit from the strobe schedule alone.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
    logic rx;
  } line_t;

  function automatic int retime_stages(input int latency);
    return (latency > 2) ? latency - 2 : 0;
  endfunction

  function automatic int count_width(input int word_w);
    return $clog2(word_w + 1);
  endfunction

  // a new word may be captured when nothing waits and at most two bits remain
  function automatic logic window_open(input int unsigned left, input logic pending);
    return !pending && (left <= 2);
  endfunction

endpackage

// File: rtl/ser10_capture.sv
module ser10_capture #(
  parameter int WORD_W = 10,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CW-1:0]     bits_left,
  output logic              accept,
  output logic              load,
  output logic [WORD_W-1:0] word_q
);
  import ser10_pkg::*;

  logic pending;

  assign accept = strobe && window_open(32'(bits_left), pending);
  assign load   = pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      word_q  <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      word_q  <= word_in;
    end else begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter #(
  parameter int WORD_W = 10,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              ser_bit,
  output logic              live,
  output logic [CW-1:0]     bits_left
);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [WORD_W-1:0] sreg;

  assign live    = (bits_left != '0);
  assign ser_bit = sreg[0] & live;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      bits_left <= '0;
    end else if (load) begin
      sreg      <= word;
      bits_left <= FULL;
    end else if (live) begin
      sreg      <= sreg >> 1;
      bits_left <= bits_left - CW'(1);
    end
  end
endmodule

// File: rtl/ser10_retime.sv
module ser10_retime #(
  parameter int DEPTH = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [DEPTH-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= (pipe << 1) | DEPTH'(d);
      end
      assign q = pipe[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/ser10_line.sv
module ser10_line (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic loop_en,
  output logic line_p,
  output logic line_n,
  output logic loop_bit
);
  import ser10_pkg::*;

  line_t st;

  always_ff @(posedge clk) begin
    if (rst)          st <= '{pos: 1'b0, neg: 1'b1, rx: 1'b0};
    else if (loop_en) st <= '{pos: 1'b1, neg: 1'b0, rx: d};
    else              st <= '{pos: d, neg: ~d, rx: 1'b0};
  end

  assign line_p   = st.pos;
  assign line_n   = st.neg;
  assign loop_bit = st.rx;
endmodule

// File: rtl/ser10_tx.sv
module ser10_tx #(
  parameter int WORD_W  = 10,
  parameter int LATENCY = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              loop_en,
  output logic              line_p,
  output logic              line_n,
  output logic              loop_bit
);
  import ser10_pkg::*;

  localparam int CW    = count_width(WORD_W);
  localparam int DEPTH = retime_stages(LATENCY);

  logic              accept_w;
  logic              load_w;
  logic              live_w;
  logic              ser_bit_w;
  logic              retimed_w;
  logic [CW-1:0]     left_w;
  logic [WORD_W-1:0] held_w;

  ser10_capture #(.WORD_W(WORD_W), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .strobe(load_stb), .word_in(word_in),
    .bits_left(left_w), .accept(accept_w), .load(load_w), .word_q(held_w)
  );

  ser10_shifter #(.WORD_W(WORD_W), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .load(load_w), .word(held_w),
    .ser_bit(ser_bit_w), .live(live_w), .bits_left(left_w)
  );

  ser10_retime #(.DEPTH(DEPTH)) u_retime (
    .clk(clk), .rst(rst), .d(ser_bit_w), .q(retimed_w)
  );

  ser10_line u_line (
    .clk(clk), .rst(rst), .d(retimed_w), .loop_en(loop_en),
    .line_p(line_p), .line_n(line_n), .loop_bit(loop_bit)
  );
endmodule

// File: rtl/ser10_tx_chk.sv
module ser10_tx_chk #(
  parameter int WORD_W = 10
) (
  input logic clk,
  input logic rst,
  input logic loop_en,
  input logic line_p,
  input logic line_n,
  input logic loop_bit,
  input logic accept_w,
  input logic load_w,
  input logic live_w,
  input logic retimed_w
);
  localparam int GW = $clog2(WORD_W + 1);
  localparam logic [GW-1:0] GMAX = GW'(WORD_W);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (accept_w) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != GMAX) begin
      gap <= gap + GW'(1);
    end
  end

  AST_ACCEPT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (accept_w && seen) |-> (gap >= GMAX - GW'(1)));                                   // R6
  AST_LOAD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    load_w |-> $past(accept_w));                                                      // R2
  AST_LIVE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_w |=> live_w);                                                               // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!line_p && line_n && !loop_bit));                                 // R1
  AST_LOOP_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loop_en)) |-> (line_p && !line_n && loop_bit == $past(retimed_w))); // R8
  AST_NORMAL_PATH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(loop_en)) |-> (!loop_bit && line_p == $past(retimed_w)));  // R9
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    line_p != line_n);                                                                // R9
endmodule

bind ser10_tx ser10_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .loop_en(loop_en), .line_p(line_p), .line_n(line_n),
  .loop_bit(loop_bit), .accept_w(accept_w), .load_w(load_w), .live_w(live_w),
  .retimed_w(retimed_w)
);

// File: tb/test_ser10_tx.sv
module test_ser10_tx;
  localparam int W     = 10;
  localparam int LAT   = 11;
  localparam int SLOTS = 32768;
  localparam logic [W-1:0] COMMA  = 10'h17C;  // 0011111010 sent first-bit-first
  localparam logic [W-1:0] COMMAN = 10'h283;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         strobe = 1'b0;
  logic         loop_en = 1'b0;
  logic [W-1:0] word_in = '0;
  wire          line_p, line_n, loop_bit;

  ser10_tx #(.WORD_W(W), .LATENCY(LAT)) i_ser10_tx (
    .clk(clk), .rst(rst), .load_stb(strobe), .word_in(word_in),
    .loop_en(loop_en), .line_p(line_p), .line_n(line_n), .loop_bit(loop_bit)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    cyc = 0;
  bit    exp_data [SLOTS];
  bit    loop_at  [SLOTS];
  int    checks = 0;
  int    fails = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  bit    loop_v = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // compare every cycle against the schedule built by the driver
  always @(negedge clk) begin
    if (chk_on && !done && cyc < SLOTS) begin
      logic ep, el;
      ep = loop_at[cyc] ? 1'b1 : exp_data[cyc];
      el = loop_at[cyc] ? exp_data[cyc] : 1'b0;
      checks++;
      if (line_p !== ep || line_n !== !ep || loop_bit !== el) begin
        fails++;
        $display("FAIL %s cycle %0d: p/n/loop actual=%b%b%b expected=%b%b%b",
                 cur_req, cyc, line_p, line_n, loop_bit, ep, !ep, el);
      end
    end
  end

  task automatic step(input bit s, input logic [W-1:0] w, input bit acc);
    @(negedge clk);
    strobe  = s;
    word_in = w;
    loop_en = loop_v;
    loop_at[cyc + 1] = loop_v;
    if (acc) for (int k = 0; k < W; k++) exp_data[cyc + 1 + LAT + k] = w[k];
  endtask

  task automatic slot(input logic [W-1:0] w);
    step(1'b1, w, 1'b1);
    for (int i = 1; i < W; i++) step(1'b0, ~w, 1'b0);  // R2: garbage after capture
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  initial begin
    idle(2);
    chk_on = 1'b1;
    idle(4);            // R1 during reset
    rst = 1'b0;
    idle(8);            // R1 after release

    cur_req = "R2/R4";  // comma and complement, back to back
    slot(COMMA); slot(COMMAN); slot(COMMA); slot(COMMAN);
    cur_req = "R7";
    idle(14);

    cur_req = "R3/R5";  // every value, continuous
    for (int v = 0; v < (1 << W); v++) slot(W'(v));
    cur_req = "R7";
    idle(20);

    cur_req = "R6";     // early strobes at +4 and +9 ignored
    step(1'b1, 10'h2A5, 1'b1);
    idle(3);
    step(1'b1, 10'h3FF, 1'b0);
    idle(4);
    step(1'b1, 10'h155, 1'b0);
    slot(10'h0F3);
    idle(20);

    loop_v  = 1'b1;
    cur_req = "R8";
    idle(3);
    slot(COMMA); slot(COMMAN);
    for (int v = 0; v < (1 << W); v++) slot(W'(v));
    idle(20);

    loop_v  = 1'b0;
    cur_req = "R9";
    idle(3);
    slot(COMMAN); slot(COMMA); slot(10'h3C1); slot(10'h01E);
    idle(20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog %s: actual=running expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule